// File: doc/BRIEF.md
# Accumulator CPU Control Sequencer

This block is the control unit and register datapath of a minimal accumulator processor. It has a 12-bit program counter (PC) and a 12-bit memory address register (MAR). It also has a 16-bit memory buffer register (MBR), a 16-bit instruction register (IR), a 16-bit accumulator (ACC) and a sticky halt flag. It reads instruction words through a synchronous memory read port, which returns data one clock after the address is presented. A fixed sequence of single-transfer states carries out each instruction. The sequencer supports five control-flow instructions: halt, no-operation, unconditional jump, jump-if-accumulator-negative and subroutine call. All register values and the current state are driven out as ports for observation. A load port lets the environment preset the accumulator.

There are eleven named states. RESET clears PC and copies PC into MAR. The fetch runs through FETCH_RD (the address is on the read port), FETCH_WAIT (MBR takes the returned word), FETCH_INC (PC is incremented), FETCH_IR (IR takes MBR) and DECODE (one idle step). Execution uses HALT (the flag is set), JUMP (PC takes the instruction's target), PREP (MAR takes PC) and the two call steps CALL_SAVE and CALL_LOAD. The transitions are fixed:
- RESET goes to FETCH_RD, and the fetch steps follow one another in order.
- DECODE goes to HALT, PREP, JUMP or CALL_SAVE, depending on the opcode and the accumulator sign.
- HALT goes to PREP, and JUMP goes to PREP.
- PREP goes to FETCH_RD, or stays in PREP while halted.
- CALL_SAVE goes to CALL_LOAD, and CALL_LOAD goes straight to FETCH_RD.

Top module: `mcpu_ctrl`

## Requirements
- R1: While rst_n is low, state_o is RESET (code 0) and PC, MAR and halt_o are zero. The first rising edge after release moves the machine to FETCH_RD (code 1).
- R2: The fetch steps FETCH_RD(1), FETCH_WAIT(2), FETCH_INC(3), FETCH_IR(4) and DECODE(5) follow one per clock. mem_rd is high only in FETCH_RD, and mem_addr always equals MAR.
- R3: MBR captures mem_rdata in FETCH_WAIT, which is the word stored at the MAR address presented in FETCH_RD. IR captures MBR in FETCH_IR.
- R4: PC increments by one modulo 4096 in FETCH_INC, so 0xFFF becomes 0x000.
- R5: The opcode is IR[15:12]. 0x0 is HLT, 0x1 is NOP, 0x2 is JMP, 0x3 is JMA and 0x4 is JSR. Codes 0x5 to 0xF behave exactly as NOP.
- R6: HLT goes DECODE, HALT(6), PREP(7) and sets halt_o. From then on, the state stays PREP, no fetch is issued and halt_o stays 1 until reset.
- R7: NOP goes DECODE, PREP, FETCH_RD. PREP loads MAR with PC.
- R8: JMP goes DECODE, JUMP(8), PREP, FETCH_RD. JUMP loads PC with IR[11:0].
- R9: JMA behaves as JMP when ACC bit 15 is 1. When ACC bit 15 is 0 it behaves as NOP and leaves PC unchanged.
- R10: JSR goes DECODE, CALL_SAVE(9), CALL_LOAD(10), FETCH_RD. CALL_SAVE loads ACC with PC zero-extended. CALL_LOAD loads PC with IR[11:0] and MBR with IR[11:0] zero-extended, and leaves MAR unchanged, so the next fetch reads the address held before the call.
- R11: When acc_ld is high at a rising edge outside CALL_SAVE, ACC takes acc_wdata. Otherwise, only CALL_SAVE changes ACC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_ld | input | 1 | Accumulator preset strobe |
| acc_wdata | input | 16 | Accumulator preset value |
| mem_rdata | input | 16 | Read data, valid one clock after the address |
| mem_rd | output | 1 | Read request |
| mem_addr | output | 12 | Read address (MAR) |
| pc_o | output | 12 | Program counter |
| mar_o | output | 12 | Memory address register |
| mbr_o | output | 16 | Memory buffer register |
| ir_o | output | 16 | Instruction register |
| acc_o | output | 16 | Accumulator |
| halt_o | output | 1 | Halt flag |
| state_o | output | 4 | Current state code |

## Verification
Every register transfer happens at the rising edge that ends the state performing it. Its result is therefore visible in the state after it: MBR in FETCH_INC, the new PC in FETCH_IR, and the jump or call target in the state after JUMP or CALL_LOAD. An instruction ends six or seven cycles after FETCH_RD, when FETCH_RD comes round again. The bench samples only at falling edges and walks an expected state list computed for every opcode and both accumulator signs. It checks each register where its write becomes visible and at the end of the instruction. It then runs the following fetch to confirm which address is read and that PC wraps.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;

    typedef enum logic [3:0] {
        ST_RESET      = 4'd0,
        ST_FETCH_RD   = 4'd1,
        ST_FETCH_WAIT = 4'd2,
        ST_FETCH_INC  = 4'd3,
        ST_FETCH_IR   = 4'd4,
        ST_DECODE     = 4'd5,
        ST_HALT       = 4'd6,
        ST_PREP       = 4'd7,
        ST_JUMP       = 4'd8,
        ST_CALL_SAVE  = 4'd9,
        ST_CALL_LOAD  = 4'd10
    } state_t;

    typedef enum logic [1:0] {
        CL_STOP,
        CL_NEXT,
        CL_JUMP,
        CL_CALL
    } iclass_t;

    localparam int OPC_HLT = 0;
    localparam int OPC_NOP = 1;
    localparam int OPC_JMP = 2;
    localparam int OPC_JMA = 3;
    localparam int OPC_JSR = 4;

    typedef struct packed {
        logic ld_mar;
        logic rd_mem;
        logic cap_mbr;
        logic inc_pc;
        logic ld_ir;
        logic jump_pc;
        logic save_pc;
        logic call_mbr;
        logic set_halt;
    } ctl_t;

endpackage

// File: rtl/mcpu_decode.sv
module mcpu_decode #(
    parameter int OP_W = 4
) (
    input  logic [OP_W-1:0]       opcode,
    input  logic                  acc_neg,
    output mcpu_pkg::iclass_t     iclass
);
    import mcpu_pkg::*;

    always_comb begin
        if (opcode == OP_W'(OPC_HLT)) begin
            iclass = CL_STOP;
        end else if (opcode == OP_W'(OPC_JMP)) begin
            iclass = CL_JUMP;
        end else if (opcode == OP_W'(OPC_JMA)) begin
            iclass = acc_neg ? CL_JUMP : CL_NEXT;
        end else if (opcode == OP_W'(OPC_JSR)) begin
            iclass = CL_CALL;
        end else begin
            iclass = CL_NEXT;
        end
    end

endmodule

// File: rtl/mcpu_fsm.sv
module mcpu_fsm (
    input  logic               clk,
    input  logic               rst_n,
    input  mcpu_pkg::iclass_t  iclass,
    input  logic               halted,
    output mcpu_pkg::state_t   state,
    output mcpu_pkg::ctl_t     ctl
);
    import mcpu_pkg::*;

    state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RESET;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RESET:      nxt = ST_FETCH_RD;
            ST_FETCH_RD:   nxt = ST_FETCH_WAIT;
            ST_FETCH_WAIT: nxt = ST_FETCH_INC;
            ST_FETCH_INC:  nxt = ST_FETCH_IR;
            ST_FETCH_IR:   nxt = ST_DECODE;
            ST_DECODE: begin
                unique case (iclass)
                    CL_STOP: nxt = ST_HALT;
                    CL_JUMP: nxt = ST_JUMP;
                    CL_CALL: nxt = ST_CALL_SAVE;
                    default: nxt = ST_PREP;
                endcase
            end
            ST_HALT:       nxt = ST_PREP;
            ST_JUMP:       nxt = ST_PREP;
            ST_PREP:       nxt = halted ? ST_PREP : ST_FETCH_RD;
            ST_CALL_SAVE:  nxt = ST_CALL_LOAD;
            ST_CALL_LOAD:  nxt = ST_FETCH_RD;
            default:       nxt = ST_RESET;
        endcase
    end

    always_comb begin
        ctl = '0;
        unique case (state)
            ST_RESET:      ctl.ld_mar   = 1'b1;
            ST_FETCH_RD:   ctl.rd_mem   = 1'b1;
            ST_FETCH_WAIT: ctl.cap_mbr  = 1'b1;
            ST_FETCH_INC:  ctl.inc_pc   = 1'b1;
            ST_FETCH_IR:   ctl.ld_ir    = 1'b1;
            ST_DECODE:     ctl          = '0;
            ST_HALT:       ctl.set_halt = 1'b1;
            ST_PREP:       ctl.ld_mar   = 1'b1;
            ST_JUMP:       ctl.jump_pc  = 1'b1;
            ST_CALL_SAVE:  ctl.save_pc  = 1'b1;
            ST_CALL_LOAD: begin
                ctl.jump_pc  = 1'b1;
                ctl.call_mbr = 1'b1;
            end
            default:       ctl = '0;
        endcase
    end

endmodule

// File: rtl/mcpu_datapath.sv
module mcpu_datapath #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  mcpu_pkg::ctl_t     ctl,
    input  logic               acc_ld,
    input  logic [DATA_W-1:0]  acc_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [ADDR_W-1:0]  pc,
    output logic [ADDR_W-1:0]  mar,
    output logic [DATA_W-1:0]  mbr,
    output logic [DATA_W-1:0]  ir,
    output logic [DATA_W-1:0]  acc,
    output logic               halted
);
    localparam int PAD_W = DATA_W - ADDR_W;

    logic [ADDR_W-1:0] target;
    assign target = ir[ADDR_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (ctl.jump_pc) begin
            pc <= target;
        end else if (ctl.inc_pc) begin
            pc <= pc + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mar <= '0;
        end else if (ctl.ld_mar) begin
            mar <= pc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mbr <= '0;
        end else if (ctl.cap_mbr) begin
            mbr <= mem_rdata;
        end else if (ctl.call_mbr) begin
            mbr <= {{PAD_W{1'b0}}, target};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir <= '0;
        end else if (ctl.ld_ir) begin
            ir <= mbr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (ctl.save_pc) begin
            acc <= {{PAD_W{1'b0}}, pc};
        end else if (acc_ld) begin
            acc <= acc_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halted <= 1'b0;
        end else if (ctl.set_halt) begin
            halted <= 1'b1;
        end
    end

endmodule

// File: rtl/mcpu_ctrl.sv
module mcpu_ctrl #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_ld,
    input  logic [DATA_W-1:0]  acc_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               mem_rd,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [ADDR_W-1:0]  pc_o,
    output logic [ADDR_W-1:0]  mar_o,
    output logic [DATA_W-1:0]  mbr_o,
    output logic [DATA_W-1:0]  ir_o,
    output logic [DATA_W-1:0]  acc_o,
    output logic               halt_o,
    output logic [3:0]         state_o
);
    import mcpu_pkg::*;

    localparam int OP_W = DATA_W - ADDR_W;

    state_t  state;
    ctl_t    ctl;
    iclass_t iclass;
    logic    halted;

    mcpu_decode #(.OP_W(OP_W)) u_decode (
        .opcode (ir_o[DATA_W-1:ADDR_W]),
        .acc_neg(acc_o[DATA_W-1]),
        .iclass (iclass)
    );

    mcpu_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .iclass(iclass),
        .halted(halted),
        .state (state),
        .ctl   (ctl)
    );

    mcpu_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .acc_ld   (acc_ld),
        .acc_wdata(acc_wdata),
        .mem_rdata(mem_rdata),
        .pc       (pc_o),
        .mar      (mar_o),
        .mbr      (mbr_o),
        .ir       (ir_o),
        .acc      (acc_o),
        .halted   (halted)
    );

    assign mem_rd   = ctl.rd_mem;
    assign mem_addr = mar_o;
    assign halt_o   = halted;
    assign state_o  = state;

endmodule

// File: rtl/mcpu_ctrl_chk.sv
module mcpu_ctrl_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        state,
    input logic [ADDR_W-1:0] pc,
    input logic [ADDR_W-1:0] mar,
    input logic [DATA_W-1:0] mbr,
    input logic [DATA_W-1:0] ir,
    input logic [DATA_W-1:0] acc,
    input logic              halt,
    input logic [DATA_W-1:0] mem_rdata
);
    import mcpu_pkg::*;

    localparam int PAD_W = DATA_W - ADDR_W;

    assert_reset_exit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_RESET |=> state == ST_FETCH_RD);

    assert_fetch_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FETCH_RD |=> state == ST_FETCH_WAIT);

    assert_wait_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FETCH_WAIT |=> state == ST_FETCH_INC);

    assert_mbr_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FETCH_WAIT |=> mbr == $past(mem_rdata));

    assert_ir_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FETCH_IR |=> ir == $past(mbr));

    assert_pc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FETCH_INC |=> pc == $past(pc) + ADDR_W'(1));

    assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

    assert_halt_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && state == ST_PREP) |=> state == ST_PREP);

    assert_prep_mar_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_PREP |=> mar == $past(pc));

    assert_jump_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_JUMP |=> (pc == $past(ir[ADDR_W-1:0]) && state == ST_PREP));

    assert_call_save_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_CALL_SAVE |=> (acc == {{PAD_W{1'b0}}, $past(pc)} && state == ST_CALL_LOAD));

    assert_call_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_CALL_LOAD |=> (pc == $past(ir[ADDR_W-1:0])
                                   && mbr == {{PAD_W{1'b0}}, $past(ir[ADDR_W-1:0])}
                                   && mar == $past(mar)
                                   && state == ST_FETCH_RD));

endmodule

bind mcpu_ctrl mcpu_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state_o),
    .pc       (pc_o),
    .mar      (mar_o),
    .mbr      (mbr_o),
    .ir       (ir_o),
    .acc      (acc_o),
    .halt     (halt_o),
    .mem_rdata(mem_rdata)
);

// File: tb/mcpu_ctrl_tb.sv
`timescale 1ns/1ps
module mcpu_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_ld = 1'b0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] mem_rdata;
    logic        mem_rd;
    logic [11:0] mem_addr;
    logic [11:0] pc_o, mar_o;
    logic [15:0] mbr_o, ir_o, acc_o;
    logic        halt_o;
    logic [3:0]  state_o;

    logic [15:0] mem [4096];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    always_ff @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    mcpu_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .acc_ld(acc_ld), .acc_wdata(acc_wdata),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .pc_o(pc_o), .mar_o(mar_o), .mbr_o(mbr_o), .ir_o(ir_o),
        .acc_o(acc_o), .halt_o(halt_o), .state_o(state_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic run_case(input int op, input bit neg);
        logic [15:0] a;
        logic [11:0] t;
        logic [15:0] w;
        logic [3:0]  seq [8];
        int          len;
        int          kind;
        logic [11:0] e_pc, e_mar;
        logic [15:0] e_acc;

        a = neg ? (16'h8000 | 16'(op * 16'h0101)) : (16'h7F00 - 16'(op));
        t = (op == 2 && neg) ? 12'hFFF : {op[3:0], (neg ? 8'hC3 : 8'h5A)};
        w = {op[3:0], t};
        for (int i = 0; i < 4096; i++) mem[i] = {4'h1, i[11:0]};
        mem[0] = w;

        // R5: class from opcode; 0 stop, 2 jump, 3 jump if neg, 4 call, rest next
        if (op == 0) kind = 0;
        else if (op == 2 || (op == 3 && neg)) kind = 2;
        else if (op == 4) kind = 3;
        else kind = 1;

        seq[0] = 4'd1; seq[1] = 4'd2; seq[2] = 4'd3; seq[3] = 4'd4; seq[4] = 4'd5;
        seq[5] = 4'd7; seq[6] = 4'd7; seq[7] = 4'd7;
        len = 6;
        e_pc = 12'd1; e_mar = 12'd1; e_acc = a;
        case (kind)
            0: begin seq[5] = 4'd6; seq[6] = 4'd7; len = 7; end
            2: begin seq[5] = 4'd8; seq[6] = 4'd7; len = 7; e_pc = t; e_mar = t; end
            3: begin seq[5] = 4'd9; seq[6] = 4'd10; len = 7; e_pc = t; e_mar = 12'd0;
                     e_acc = 16'd1; end
            default: ;
        endcase

        rst_n = 1'b0;
        acc_ld = 1'b0;
        repeat (2) @(negedge clk);
        chk(state_o == 4'd0, "R1", "reset state", state_o, 0);
        chk(pc_o == 12'd0 && mar_o == 12'd0, "R1", "reset pc/mar", {pc_o, mar_o}, 0);
        chk(halt_o == 1'b0, "R1", "reset halt", halt_o, 0);
        rst_n = 1'b1;
        acc_ld = 1'b1;
        acc_wdata = a;
        @(negedge clk);
        acc_ld = 1'b0;

        for (int k = 0; k < len; k++) begin
            chk(state_o == seq[k], (k < 5) ? "R2" : "R5", $sformatf("op%0d step%0d state", op, k),
                state_o, seq[k]);
            chk(mem_rd == (seq[k] == 4'd1) && mem_addr == mar_o, "R2", "read port",
                {mem_rd, mem_addr}, {(seq[k] == 4'd1), mar_o});
            if (k == 2) chk(mbr_o == w, "R3", "mbr captured", mbr_o, w);
            if (k == 3) chk(pc_o == 12'd1, "R4", "pc incremented", pc_o, 1);
            if (k == 4) chk(ir_o == w, "R3", "ir loaded", ir_o, w);
            if (k == 6 && kind == 3)
                chk(acc_o == 16'd1, "R10", "pc saved to acc", acc_o, 1);
            @(negedge clk);
        end

        if (kind == 0) begin
            for (int c = 0; c < 20; c++) begin
                chk(state_o == 4'd7 && !mem_rd, "R6", "parked in prep", state_o, 7);
                chk(halt_o == 1'b1, "R6", "halt stays set", halt_o, 1);
                @(negedge clk);
            end
            chk(pc_o == 12'd1 && mar_o == 12'd1, "R7", "halt path prep mar", mar_o, 1);
            chk(acc_o == a, "R11", "acc preload kept", acc_o, a);
        end else begin
            chk(state_o == 4'd1, "R2", "back to fetch", state_o, 1);
            chk(halt_o == 1'b0, "R6", "no halt", halt_o, 0);
            chk(pc_o == e_pc, (kind == 2) ? "R8" : ((kind == 3) ? "R10" : "R9"),
                $sformatf("op%0d pc", op), pc_o, e_pc);
            chk(mar_o == e_mar, (kind == 3) ? "R10" : "R7", "mar", mar_o, e_mar);
            chk(acc_o == e_acc, (kind == 3) ? "R10" : "R11", "acc", acc_o, e_acc);
            if (kind == 3)
                chk(mbr_o == {4'h0, t}, "R10", "mbr target", mbr_o, {4'h0, t});
            repeat (4) @(negedge clk);
            chk(state_o == 4'd5, "R2", "second decode", state_o, 5);
            chk(ir_o == mem[e_mar], "R3", "second fetch word", ir_o, mem[e_mar]);
            chk(pc_o == e_pc + 12'd1, "R4", "pc wrap/inc", pc_o, e_pc + 12'd1);
        end
    endtask

    initial begin
        for (int op = 0; op < 16; op++) begin
            run_case(op, 1'b0);
            run_case(op, 1'b1);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule